// File: doc/BRIEF.md
# Source-Learning Forwarding Table for a Four-Port Switch

This block decides where each frame of a four-port Ethernet switch goes. Every frame header that arrives offers its source address and the number of the port it came in on. The block records that pair in a small fully associative table. The same header also offers its destination address, and the block answers with a bitmask of egress ports. Bit n of the mask stands for port n.

The answer takes one of four forms. A destination that was learned is sent to its recorded port. An unknown destination or the all-ones broadcast address is flooded to every port except the ingress port. An address held back for the local processor raises a dedicated CPU flag instead of any port bit.

The table has 16 entries. Each entry ages on a periodic tick and is dropped after a fixed number of ticks. When a new address arrives, it takes the slot under a round-robin pointer. That slot holds the earliest insertion, so once the table is full the oldest entry is the one replaced.

Top module: `mac_fwd_table`

## Requirements
- R1: A lookup request in cycle t yields `res_valid` high in cycle t+1 only. After reset, `res_valid` is low and the table holds no entries.
- R2: If the destination matches a live entry, `res_mask` has only the bit of that entry's port set (bit n = port n), and `res_cpu` is 0.
- R3: If the destination matches no live entry, `res_mask` has all four bits set except the bit of the lookup's ingress port.
- R4: A destination of all ones (48'hFFFF_FFFF_FFFF) is flooded to every port except the ingress port.
- R5: A destination equal to the reserved processor address (parameter, default 48'h0200_0000_00FE) gives `res_cpu`=1 and `res_mask`=0.
- R6: Learning an address that is already in the table updates that entry's port and restarts its age. No second entry is created.
- R7: A learned entry stays live through AGE_LIMIT-1 age ticks (default 300) and stops matching once the AGE_LIMIT-th tick has been counted.
- R8: New addresses fill slots in round-robin order. The seventeenth distinct address replaces the first one learned, and later ones are kept.
- R9: A source address whose group bit (bit 40, the lowest bit of the first octet) is 1 is never learned.
- R10: A lookup in the same cycle as a learn of the same address sees the table as it was before that learn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lrn_valid | input | 1 | Learn request strobe |
| lrn_mac | input | 48 | Source address to record |
| lrn_port | input | 2 | Ingress port of the learned frame |
| lkp_valid | input | 1 | Lookup request strobe |
| lkp_mac | input | 48 | Destination address to resolve |
| lkp_port | input | 2 | Ingress port of the looked-up frame |
| age_tick | input | 1 | One-cycle pulse that ages every live entry |
| res_valid | output | 1 | Forwarding result valid |
| res_mask | output | 4 | Egress port bitmask |
| res_cpu | output | 1 | Frame goes to the local processor |

## Verification
A lookup result appears exactly one clock after its request. A learn or age tick changes the table at the clock edge where it is presented, so a lookup in the following cycle already sees the change. The bench drives each request on a falling edge and pushes the expected result into a queue at that moment. A monitor samples on every later falling edge and pops one entry whenever `res_valid` is high, so a result that comes early, late or unexpected shows up as a mismatch or an unmatched item. The aging boundary is checked by counting ticks to one short of the limit and then to the limit.

// File: rtl/mac_fwd_pkg.sv
package mac_fwd_pkg;

    localparam int MAC_W  = 48;
    localparam int NPORT  = 4;
    localparam int PORT_W = $clog2(NPORT);
    localparam int GROUP_BIT = 40;

    typedef logic [MAC_W-1:0]  mac_t;
    typedef logic [PORT_W-1:0] port_t;
    typedef logic [NPORT-1:0]  pmask_t;

    typedef struct packed {
        logic   valid;
        pmask_t mask;
        logic   cpu;
    } fwd_res_t;

    typedef struct packed {
        logic  valid;
        mac_t  mac;
        port_t port;
    } req_t;

    localparam mac_t BCAST_MAC = '1;

    function automatic logic mac_is_group(mac_t m);
        return m[GROUP_BIT];
    endfunction

    function automatic pmask_t port_bit(port_t p);
        return pmask_t'(1) << p;
    endfunction

    function automatic pmask_t flood_mask(port_t ingress);
        return ~port_bit(ingress);
    endfunction

endpackage

// File: rtl/mac_fwd_match.sv
module mac_fwd_match
    import mac_fwd_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic [NUM_ENTRIES-1:0] ent_valid,
    input  mac_t                   ent_mac  [NUM_ENTRIES],
    input  port_t                  ent_port [NUM_ENTRIES],
    input  mac_t                   key,
    output logic [NUM_ENTRIES-1:0] hit_vec,
    output logic                   hit,
    output port_t                  hit_port
);
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = ent_valid[i] && (ent_mac[i] == key);
    end

    always_comb begin
        hit_port = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (hit_vec[i]) hit_port = hit_port | ent_port[i];
        end
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/mac_fwd_store.sv
module mac_fwd_store
    import mac_fwd_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int AGE_LIMIT   = 300,
    localparam int AGE_W = $clog2(AGE_LIMIT + 1),
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   age_tick,
    input  req_t                   wr,
    input  logic [NUM_ENTRIES-1:0] wr_hit_vec,
    output logic [NUM_ENTRIES-1:0] ent_valid,
    output mac_t                   ent_mac  [NUM_ENTRIES],
    output port_t                  ent_port [NUM_ENTRIES]
);
    localparam logic [AGE_W-1:0] LAST_AGE = AGE_W'(AGE_LIMIT - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    logic             wr_hit;
    logic [IDX_W-1:0] rr_ptr;

    assign wr_hit = |wr_hit_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
        end else if (wr.valid && !wr_hit) begin
            rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        logic [AGE_W-1:0] age;
        logic             sel;

        assign sel = wr.valid && (wr_hit ? wr_hit_vec[i] : (rr_ptr == IDX_W'(i)));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_valid[i] <= 1'b0;
                ent_mac[i]   <= '0;
                ent_port[i]  <= '0;
                age          <= '0;
            end else if (sel) begin
                ent_valid[i] <= 1'b1;
                ent_mac[i]   <= wr.mac;
                ent_port[i]  <= wr.port;
                age          <= '0;
            end else if (age_tick && ent_valid[i]) begin
                if (age == LAST_AGE) begin
                    ent_valid[i] <= 1'b0;
                    age          <= '0;
                end else begin
                    age <= age + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mac_fwd_decide.sv
module mac_fwd_decide
    import mac_fwd_pkg::*;
#(
    parameter mac_t CPU_MAC = 48'h0200_0000_00FE
) (
    input  logic     clk,
    input  logic     rst,
    input  req_t     lkp,
    input  logic     hit,
    input  port_t    hit_port,
    output fwd_res_t res
);
    fwd_res_t nxt;

    always_comb begin
        nxt.valid = lkp.valid;
        nxt.cpu   = 1'b0;
        nxt.mask  = '0;
        if (lkp.mac == CPU_MAC) begin
            nxt.cpu = 1'b1;
        end else if (lkp.mac == BCAST_MAC || !hit) begin
            nxt.mask = flood_mask(lkp.port);
        end else begin
            nxt.mask = port_bit(hit_port);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res <= '0;
        else     res <= nxt;
    end
endmodule

// File: rtl/mac_fwd_table.sv
module mac_fwd_table
    import mac_fwd_pkg::*;
#(
    parameter int   NUM_ENTRIES = 16,
    parameter int   AGE_LIMIT   = 300,
    parameter mac_t CPU_MAC     = 48'h0200_0000_00FE
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        lrn_valid,
    input  logic [47:0] lrn_mac,
    input  logic [1:0]  lrn_port,
    input  logic        lkp_valid,
    input  logic [47:0] lkp_mac,
    input  logic [1:0]  lkp_port,
    input  logic        age_tick,
    output logic        res_valid,
    output logic [3:0]  res_mask,
    output logic        res_cpu
);
    logic [NUM_ENTRIES-1:0] ent_valid;
    mac_t                   ent_mac  [NUM_ENTRIES];
    port_t                  ent_port [NUM_ENTRIES];

    req_t                   wr_req, lk_req;
    logic [NUM_ENTRIES-1:0] lrn_hit_vec, lkp_hit_vec;
    logic                   lrn_hit, lkp_hit;
    port_t                  lrn_hit_port, lkp_hit_port;
    fwd_res_t               res;

    assign wr_req.valid = lrn_valid && !mac_is_group(lrn_mac);
    assign wr_req.mac   = lrn_mac;
    assign wr_req.port  = lrn_port;

    assign lk_req.valid = lkp_valid;
    assign lk_req.mac   = lkp_mac;
    assign lk_req.port  = lkp_port;

    mac_fwd_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_lrn_match (
        .ent_valid (ent_valid),
        .ent_mac   (ent_mac),
        .ent_port  (ent_port),
        .key       (lrn_mac),
        .hit_vec   (lrn_hit_vec),
        .hit       (lrn_hit),
        .hit_port  (lrn_hit_port)
    );

    mac_fwd_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_lkp_match (
        .ent_valid (ent_valid),
        .ent_mac   (ent_mac),
        .ent_port  (ent_port),
        .key       (lkp_mac),
        .hit_vec   (lkp_hit_vec),
        .hit       (lkp_hit),
        .hit_port  (lkp_hit_port)
    );

    mac_fwd_store #(.NUM_ENTRIES(NUM_ENTRIES), .AGE_LIMIT(AGE_LIMIT)) u_store (
        .clk        (clk),
        .rst        (rst),
        .age_tick   (age_tick),
        .wr         (wr_req),
        .wr_hit_vec (lrn_hit_vec),
        .ent_valid  (ent_valid),
        .ent_mac    (ent_mac),
        .ent_port   (ent_port)
    );

    mac_fwd_decide #(.CPU_MAC(CPU_MAC)) u_decide (
        .clk      (clk),
        .rst      (rst),
        .lkp      (lk_req),
        .hit      (lkp_hit),
        .hit_port (lkp_hit_port),
        .res      (res)
    );

    assign res_valid = res.valid;
    assign res_mask  = res.mask;
    assign res_cpu   = res.cpu;

    logic unused_lrn;
    assign unused_lrn = lrn_hit ^ (|lrn_hit_port) ^ (|lkp_hit_vec);
endmodule

// File: rtl/mac_fwd_chk.sv
module mac_fwd_chk
    import mac_fwd_pkg::*;
#(
    parameter int   NUM_ENTRIES = 16,
    parameter mac_t CPU_MAC     = 48'h0200_0000_00FE
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   lkp_valid,
    input logic [47:0]            lkp_mac,
    input logic [1:0]             lkp_port,
    input logic                   res_valid,
    input logic [3:0]             res_mask,
    input logic                   res_cpu,
    input logic [NUM_ENTRIES-1:0] ent_valid,
    input mac_t                   ent_mac [NUM_ENTRIES]
);
    int dup_cnt;
    int grp_cnt;

    always_comb begin
        dup_cnt = 0;
        grp_cnt = 0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (ent_valid[i] && mac_is_group(ent_mac[i])) grp_cnt++;
            for (int j = i + 1; j < NUM_ENTRIES; j++) begin
                if (ent_valid[i] && ent_valid[j] && ent_mac[i] == ent_mac[j]) dup_cnt++;
            end
        end
    end

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        lkp_valid |=> res_valid); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !lkp_valid |=> !res_valid); // R1
    AST_BCAST_FLOOD: assert property (@(posedge clk) disable iff (rst)
        (lkp_valid && lkp_mac == BCAST_MAC) |=>
            (!res_cpu && res_mask == ~(4'b0001 << $past(lkp_port)))); // R4
    AST_CPU_DELIVER: assert property (@(posedge clk) disable iff (rst)
        (lkp_valid && lkp_mac == CPU_MAC) |=> (res_cpu && res_mask == 4'b0000)); // R5
    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_cpu) |->
            ($countones(res_mask) == 1 || $countones(res_mask) == 3)); // R2
    AST_NO_DUP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        dup_cnt == 0); // R6
    AST_NO_GROUP_LEARN: assert property (@(posedge clk) disable iff (rst)
        grp_cnt == 0); // R9
endmodule

bind mac_fwd_table mac_fwd_chk #(.NUM_ENTRIES(NUM_ENTRIES), .CPU_MAC(CPU_MAC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lkp_valid (lkp_valid),
    .lkp_mac   (lkp_mac),
    .lkp_port  (lkp_port),
    .res_valid (res_valid),
    .res_mask  (res_mask),
    .res_cpu   (res_cpu),
    .ent_valid (ent_valid),
    .ent_mac   (ent_mac)
);

// File: tb/mac_fwd_table_tb_top.sv
module mac_fwd_table_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam logic [47:0] CPU_ADDR = 48'h0200_0000_00FE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lrn_valid = 1'b0;
    logic [47:0] lrn_mac = '0;
    logic [1:0]  lrn_port = '0;
    logic        lkp_valid = 1'b0;
    logic [47:0] lkp_mac = '0;
    logic [1:0]  lkp_port = '0;
    logic        age_tick = 1'b0;
    logic        res_valid;
    logic [3:0]  res_mask;
    logic        res_cpu;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_fwd_table dut_i (
        .clk(clk), .rst(rst),
        .lrn_valid(lrn_valid), .lrn_mac(lrn_mac), .lrn_port(lrn_port),
        .lkp_valid(lkp_valid), .lkp_mac(lkp_mac), .lkp_port(lkp_port),
        .age_tick(age_tick),
        .res_valid(res_valid), .res_mask(res_mask), .res_cpu(res_cpu)
    );

    function automatic logic [3:0] flood(logic [1:0] p);
        return ~(4'b0001 << p);
    endfunction

    function automatic logic [3:0] onep(logic [1:0] p);
        return 4'b0001 << p;
    endfunction

    // monitor: pops one expectation for every result the block produces
    always @(negedge clk) begin
        if (!rst && !done && res_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R1 unexpected result: got mask=%b cpu=%b, expected none", res_mask, res_cpu);
            end else begin
                logic [4:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({res_mask, res_cpu} !== e) begin
                    bad++;
                    $display("FAIL %s: got mask=%b cpu=%b, expected mask=%b cpu=%b",
                             t, res_mask, res_cpu, e[4:1], e[0]);
                end
            end
        end
    end

    task automatic learn(input logic [47:0] m, input logic [1:0] p);
        @(negedge clk);
        lrn_valid = 1'b1; lrn_mac = m; lrn_port = p;
        @(negedge clk);
        lrn_valid = 1'b0;
    endtask

    task automatic lookup(input logic [47:0] m, input logic [1:0] p,
                          input logic [3:0] emask, input logic ecpu, input string t);
        @(negedge clk);
        lkp_valid = 1'b1; lkp_mac = m; lkp_port = p;
        exp_q.push_back({emask, ecpu});
        tag_q.push_back(t);
        @(negedge clk);
        lkp_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            age_tick = 1'b1;
        end
        @(negedge clk);
        age_tick = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic drain;
        repeat (3) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R1 missing results: got %0d outstanding, expected 0", exp_q.size());
            exp_q.delete(); tag_q.delete();
        end
    endtask

    initial begin
        logic [47:0] a_mac, b_mac, c_mac, d_mac, g_mac;
        a_mac = 48'h0010_2030_4050;
        b_mac = 48'h0010_2030_4051;
        c_mac = 48'h0010_2030_4052;
        d_mac = 48'h0010_2030_4053;
        g_mac = 48'h0100_5E00_0001;

        do_reset();
        total++;
        if (res_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: got res_valid=%b, expected 0", res_valid);
        end

        // empty table: every unicast misses
        lookup(a_mac, 2'd1, flood(2'd1), 1'b0, "R3 miss on empty table");
        learn(a_mac, 2'd2);
        lookup(a_mac, 2'd0, onep(2'd2), 1'b0, "R2 learned hit port 2");
        lookup(48'hFFFF_FFFF_FFFF, 2'd3, flood(2'd3), 1'b0, "R4 broadcast from port 3");
        lookup(CPU_ADDR, 2'd1, 4'b0000, 1'b1, "R5 processor address");
        lookup(d_mac, 2'd2, flood(2'd2), 1'b0, "R3 unknown from port 2");

        // relearn moves the entry
        learn(a_mac, 2'd3);
        lookup(a_mac, 2'd1, onep(2'd3), 1'b0, "R6 port updated on relearn");

        // group source must not be learned
        learn(g_mac, 2'd1);
        lookup(g_mac, 2'd0, flood(2'd0), 1'b0, "R9 group source not learned");

        // same-cycle learn and lookup of a new address
        @(negedge clk);
        lrn_valid = 1'b1; lrn_mac = b_mac; lrn_port = 2'd2;
        lkp_valid = 1'b1; lkp_mac = b_mac; lkp_port = 2'd0;
        exp_q.push_back({flood(2'd0), 1'b0});
        tag_q.push_back("R10 lookup sees pre-learn table");
        @(negedge clk);
        lrn_valid = 1'b0; lkp_valid = 1'b0;
        lookup(b_mac, 2'd0, onep(2'd2), 1'b0, "R10 learn visible next cycle");
        drain();

        // aging boundary
        do_reset();
        learn(c_mac, 2'd1);
        ticks(299);
        lookup(c_mac, 2'd0, onep(2'd1), 1'b0, "R7 live after limit-1 ticks");
        ticks(1);
        lookup(c_mac, 2'd0, flood(2'd0), 1'b0, "R7 expired at limit");

        // refresh restarts age
        learn(d_mac, 2'd2);
        ticks(200);
        learn(d_mac, 2'd3);
        ticks(200);
        lookup(d_mac, 2'd0, onep(2'd3), 1'b0, "R6 age restarted on relearn");
        drain();

        // reset clears the table
        do_reset();
        lookup(d_mac, 2'd1, flood(2'd1), 1'b0, "R1 table empty after reset");

        // round-robin replacement
        for (int k = 1; k <= 17; k++) learn(48'h0000_1000_0000 + 48'(k), 2'(k % 4));
        lookup(48'h0000_1000_0001, 2'd0, flood(2'd0), 1'b0, "R8 first entry replaced");
        lookup(48'h0000_1000_0002, 2'd0, onep(2'd2), 1'b0, "R8 second entry kept");
        lookup(48'h0000_1000_0011, 2'd0, onep(2'd1), 1'b0, "R8 newest entry present");
        drain();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule